// File: doc/BRIEF.md
# Interrupt Level Controller with Periodic Tick

This block holds a 32-bit interrupt control word and drives seven interrupt request lines, one for each processor priority level from 1 to 7. Software writes the word through a byte-masked write port. The top byte carries the controls. A master enable gates everything. Three bits post software interrupts at levels 1, 2 and 3. One bit enables the periodic clock interrupt and also acknowledges it.

A prescaler divides the system clock down to a periodic tick, 100 Hz at the default parameters. On each tick, if the stored word has both the master enable and the clock enable set, level 7 is asserted. Level 7 stays asserted until software acknowledges it or clears the master enable. Software levels stay asserted until the master enable is cleared. Levels 4 to 6 have no source in this block and stay low.

Top module: `irq_level_ctl`

## Requirements
- R1: After reset the control word reads 0x00000000 and all seven request lines are low.
- R2: A write updates bits 8k+7..8k only where wr_be_i[k] is 1. The other bits keep their value, and rd_data_o always shows the stored word.
- R3: A write with wr_be_i[3]=1 and data bit 24 (master enable) equal to 0 drives all seven request lines low from the next cycle.
- R4: A write with wr_be_i[3]=1 and data bit 24 set asserts level 1, 2 or 3 on the next cycle for each of data bits 25, 26 and 27 that is 1. Request line irq_o[k] is level k+1.
- R5: Writing bits 25 to 27 as 0 while bit 24 is set leaves levels 1 to 3 unchanged. Only a master-enable clear drops them.
- R6: A write with wr_be_i[3]=1, data bit 24 set and data bit 31 (clock enable) equal to 0 deasserts level 7 on the next cycle.
- R7: A tick fires on every DIV-th clock edge after reset, where DIV = CLK_HZ/TICK_HZ. On a tick, level 7 is set if the stored word has bits 31 and 24 both set. Otherwise the tick does nothing.
- R8: The tick condition is taken from the word held before any write in the same cycle. A tick that coincides with an acknowledge leaves level 7 high. A tick that coincides with a master-enable clear leaves it low.
- R9: Levels 4, 5 and 6 (irq_o[5:3]) are always low.
- R10: A write with wr_be_i[3]=0 only merges the data into the word. It changes no request line.
- R11: Writing bit 31 as 1 does not by itself assert level 7. Level 7 rises only on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_be_i | input | 4 | Byte-lane enables; bit k covers data bits 8k+7..8k |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Stored control word |
| irq_o | output | 7 | Request lines; bit k is priority level k+1 |

## Verification
The bench builds the block with CLK_HZ=1000 and TICK_HZ=100, so a tick fires every 10 clocks instead of every 200000. At that rate, many tick periods fit in a short run. The bench counts clock edges on its own, so it knows exactly which edge carries a tick. It can therefore place an acknowledge or a master-enable clear on that same edge, and it can check that level 7 stays low on the edges just before a tick.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned NUM_LVL  = 7;
  localparam int unsigned CTL_LANE = 3;
  localparam int unsigned BIT_MEN  = 24;
  localparam int unsigned BIT_SW1  = 25;
  localparam int unsigned BIT_SW3  = 27;
  localparam int unsigned BIT_CLK  = 31;
  localparam int unsigned LVL_CLK  = 6;

  typedef struct packed {
    logic men_clr;
    logic men_set;
    logic ack;
    logic [2:0] sw;
  } ctl_ev_t;

  function automatic ctl_ev_t decode_ctl(input logic we, input logic lane_en,
                                          input logic [WORD_W-1:0] d);
    ctl_ev_t ev;
    logic hit;
    hit        = we & lane_en;
    ev.men_clr = hit & ~d[BIT_MEN];
    ev.men_set = hit & d[BIT_MEN];
    ev.ack     = ev.men_set & ~d[BIT_CLK];
    ev.sw      = ev.men_set ? d[BIT_SW3:BIT_SW1] : 3'b000;
    return ev;
  endfunction
endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R7
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/irq_ctl_word.sv
module irq_ctl_word
  import irq_level_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      word_q[8*k +: 8] <= '0;
      else if (wr_en_i && wr_be_i[k])   word_q[8*k +: 8] <= wr_data_i[8*k +: 8];
    end
  end

  assign word_o = word_q;

  // R2
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (&wr_be_i)) |=> (word_o == $past(wr_data_i)));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(word_o));
endmodule

// File: rtl/irq_lvl_ctl.sv
module irq_lvl_ctl
  import irq_level_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic               ctl_lane_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [NUM_LVL-1:0] lvl_o
);
  ctl_ev_t ev;
  logic tick_arm;
  logic [NUM_LVL-1:0] lvl_q, lvl_d;

  assign ev       = decode_ctl(wr_en_i, ctl_lane_i, wr_data_i);
  assign tick_arm = tick_i & word_i[BIT_CLK] & word_i[BIT_MEN];

  // Priority: master clear > tick set > acknowledge clear
  always_comb begin
    lvl_d = lvl_q;
    lvl_d[2:0] = lvl_q[2:0] | ev.sw;
    if (ev.ack)   lvl_d[LVL_CLK] = 1'b0;
    if (tick_arm) lvl_d[LVL_CLK] = 1'b1;
    lvl_d[5:3] = 3'b000;
    if (ev.men_clr) lvl_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  // R3
  master_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctl_lane_i && !wr_data_i[BIT_MEN]) |=> (lvl_o == '0));
  // R4
  sw_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctl_lane_i && wr_data_i[BIT_MEN] && wr_data_i[BIT_SW1]) |=> lvl_o[0]);
  // R5
  sw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ctl_lane_i && !wr_data_i[BIT_MEN])
      |=> ((lvl_o[2:0] & $past(lvl_o[2:0])) == $past(lvl_o[2:0])));
  // R8
  tick_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && word_i[BIT_CLK] && word_i[BIT_MEN]
      && !(wr_en_i && ctl_lane_i && !wr_data_i[BIT_MEN])) |=> lvl_o[LVL_CLK]);
  // R11
  clk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_o[LVL_CLK] && !tick_i) |=> !lvl_o[LVL_CLK]);
  // R9
  mid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o[5:3] == 3'b000);
  // R10
  no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(wr_en_i && ctl_lane_i)) |=> $stable(lvl_o));
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
  import irq_level_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 20000000,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic [6:0]  irq_o
);
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic tick;
  logic [WORD_W-1:0] word;

  irq_tick_div #(.DIV(DIV)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  irq_ctl_word i_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_be_i   (wr_be_i),
    .wr_data_i (wr_data_i),
    .word_o    (word)
  );

  irq_lvl_ctl i_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wr_en_i    (wr_en_i),
    .ctl_lane_i (wr_be_i[CTL_LANE]),
    .wr_data_i  (wr_data_i),
    .word_i     (word),
    .lvl_o      (irq_o)
  );

  assign rd_data_o = word;

  initial begin
    if (DIV < 2) $error("tick divider must be at least 2");
  end
endmodule

// File: tb/test_irq_level_ctl.sv
module test_irq_level_ctl;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned TICK_HZ = 100;
  localparam int unsigned DIV = CLK_HZ / TICK_HZ;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = 4'h0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [6:0]  irq_o;

  int checks = 0;
  int failures = 0;
  int ecnt = 0;
  bit done = 1'b0;

  irq_level_ctl #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) i_irq_level_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ecnt <= 0;
    else         ecnt <= ecnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // call at a negedge; the write lands on the next posedge
  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    wr_en_i = 1'b1; wr_data_i = d; wr_be_i = be;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = 4'h0;
  endtask

  task automatic phase(input int p);
    @(negedge clk_i);
    while ((ecnt % DIV) != p) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 word", rd_data_o, 32'h0);
    chk("R1 irq", {25'h0, irq_o}, 32'h0);
  endtask

  task automatic t_merge();
    phase(1);
    wr(32'h11223344, 4'b0101);
    chk("R2 lanes0,2", rd_data_o, 32'h00220044);
    chk("R10 no level", {25'h0, irq_o}, 32'h0);
    wr(32'hAABBCCDD, 4'b1010);
    chk("R2 lanes1,3", rd_data_o, 32'hAA22CC44);
    wr(32'h0, 4'hF);
  endtask

  task automatic t_sw();
    phase(1);
    wr(32'h03000000, 4'hF);
    chk("R4 level1", {25'h0, irq_o}, 32'h01);
    wr(32'h0D000000, 4'hF);
    chk("R4 level2,3", {25'h0, irq_o}, 32'h07);
    wr(32'h01000000, 4'hF);
    chk("R5 sticky", {25'h0, irq_o}, 32'h07);
    wr(32'h00000000, 4'b0111);
    chk("R10 lane3 off", {25'h0, irq_o}, 32'h07);
    chk("R2 lane3 kept", rd_data_o, 32'h01000000);
    chk("R9 levels 4-6", {29'h0, irq_o[5:3]}, 32'h0);
    wr(32'h00000000, 4'b1000);
    chk("R3 master clear", {25'h0, irq_o}, 32'h0);
  endtask

  task automatic t_tick();
    phase(0);
    wr(32'h81000000, 4'hF);
    chk("R11 no direct set", {31'h0, irq_o[6]}, 32'h0);
    phase(DIV - 1);
    chk("R7 before tick", {31'h0, irq_o[6]}, 32'h0);
    @(negedge clk_i);
    chk("R7 tick sets", {31'h0, irq_o[6]}, 32'h1);
    chk("R9 only level7", {25'h0, irq_o}, 32'h40);
    wr(32'h01000000, 4'hF);
    chk("R6 ack", {31'h0, irq_o[6]}, 32'h0);
    phase(1);
    chk("R7 clock disabled", {31'h0, irq_o[6]}, 32'h0);
  endtask

  task automatic t_races();
    wr(32'h81000000, 4'hF);
    phase(1);
    chk("R7 rearmed", {31'h0, irq_o[6]}, 32'h1);
    phase(DIV - 1);
    wr(32'h01000000, 4'hF);
    chk("R8 tick beats ack", {31'h0, irq_o[6]}, 32'h1);
    wr(32'h01000000, 4'hF);
    chk("R6 later ack", {31'h0, irq_o[6]}, 32'h0);
    wr(32'h81000000, 4'hF);
    phase(DIV - 1);
    wr(32'h00000000, 4'b1000);
    chk("R8 clear beats tick", {25'h0, irq_o}, 32'h0);
    wr(32'h80000000, 4'hF);
    phase(1);
    chk("R7 master off no tick", {25'h0, irq_o}, 32'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_merge();
    t_sw();
    t_tick();
    t_races();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule